// File: doc/BRIEF.md
# Multi-Mode Word Shifter with Bit Probe

This block is a purely combinational shifter for a 32-bit datapath. A data word, an unsigned shift amount and a two-bit operation code go in; the shifted word and a carry bit come out in the same cycle. The operation code picks one of four operations: logical left, arithmetic right, logical right or rotate right. Each operation has its own rule for amounts that reach or pass the word width.

The carry output holds the last bit that left the word. A second, independent path reads one bit of the input word at a given index and reports its value. An index past the top bit reads as zero.

The word width must be a power of two. The amount field must be wide enough to hold the word width, because amounts at or above the width are legal inputs.

Top module: `bsh_top`

## Requirements
- R1: The operation code selects the operation as follows: 0 = logical left, 1 = arithmetic right, 2 = logical right, 3 = rotate right.
- R2: With an amount of zero, every operation returns the input word unchanged and drives carry to 0.
- R3: Logical left by s in 1..31 moves bits up and fills the bottom with zeros; carry is input bit 32−s (shift by 31 of 0xF0000001 gives 0x80000000).
- R4: Logical left by 32 or more returns 0; carry is input bit 0 at exactly 32 and 0 above (0xF0000001 by 32 or 100 gives 0).
- R5: Logical right by s in 1..31 moves bits down and fills the top with zeros; carry is input bit s−1.
- R6: Logical right by 32 or more returns 0; carry is input bit 31 at exactly 32 and 0 above.
- R7: Arithmetic right by s in 1..31 fills the top with copies of input bit 31; carry is input bit s−1 (0xFF000100 by 8 gives 0xFFFF0001, 0xFFFFFFF1 by 2 gives 0xFFFFFFFC).
- R8: Arithmetic right by 32 or more returns all ones for a word with bit 31 set and all zeros otherwise; carry equals input bit 31.
- R9: Rotate right uses the amount modulo 32, so amounts 0, 32 and 64 return the input. For a nonzero amount, carry is bit 31 of the result (0x0E000010 by 12 gives 0x0100E000, 0x00FFFF00 by 12 gives 0xF0000FFF).
- R10: The probe output equals input bit b for an index b in 0..31 and is 0 for any larger index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | DATA_W (32) | Word to shift and to probe |
| amt_i | input | AMT_W (8) | Unsigned shift amount |
| kind_i | input | 2 | Operation code |
| probe_idx_i | input | AMT_W (8) | Bit index for the probe path |
| result_o | output | DATA_W (32) | Shifted word |
| carry_o | output | 1 | Last bit shifted out |
| probe_o | output | 1 | Value of the probed bit |

## Verification
The bench builds the block with its defaults: a 32-bit word and 8-bit amount and index fields. With an 8-bit field, amounts of exactly 32, of 64, of 100 and up to 255 can be driven. This reaches the boundary where each operation switches to its out-of-range rule and checks that rotation wraps more than once. Probe indices from 32 to 255 exercise the rule that an index past the top bit reads as zero.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_ASR = 2'd1,
        SK_LSR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic in_range;  // amount below the word width
        logic is_zero;   // amount equals zero
        logic exact_w;   // amount equals the word width
    } amt_info_t;

endpackage

// File: rtl/bsh_amt_decode.sv
module bsh_amt_decode
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int LOG_W = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] amt_i,
    output amt_info_t        info_o,
    output logic [LOG_W-1:0] low_o
);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(DATA_W);

    always_comb begin
        info_o.in_range = (amt_i < W_AMT);
        info_o.is_zero  = (amt_i == '0);
        info_o.exact_w  = (amt_i == W_AMT);
        low_o           = amt_i[LOG_W-1:0];
    end
endmodule

// File: rtl/bsh_core.sv
module bsh_core
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LOG_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  shift_kind_e       kind_i,
    input  amt_info_t         info_i,
    input  logic [LOG_W-1:0]  low_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    logic [DATA_W-1:0] lft [0:LOG_W];
    logic [DATA_W-1:0] rgt [0:LOG_W];
    logic [DATA_W-1:0] rot [0:LOG_W];
    logic              sign;
    logic              fill;
    logic [LOG_W-1:0]  up_idx;
    logic [LOG_W-1:0]  dn_idx;

    assign sign   = data_i[DATA_W-1];
    assign fill   = (kind_i == SK_ASR) ? sign : 1'b0;
    assign up_idx = ~low_i + LOG_W'(1);      // DATA_W - low modulo DATA_W
    assign dn_idx = low_i - LOG_W'(1);

    assign lft[0] = data_i;
    assign rgt[0] = data_i;
    assign rot[0] = data_i;

    // one stage per amount bit, each moving by a power of two
    for (genvar k = 0; k < LOG_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign lft[k+1] = low_i[k] ? {lft[k][DATA_W-1-SH:0], {SH{1'b0}}} : lft[k];
        assign rgt[k+1] = low_i[k] ? {{SH{fill}}, rgt[k][DATA_W-1:SH]} : rgt[k];
        assign rot[k+1] = low_i[k] ? {rot[k][SH-1:0], rot[k][DATA_W-1:SH]} : rot[k];
    end

    always_comb begin
        result_o = data_i;
        carry_o  = 1'b0;
        unique case (kind_i)
            SK_LSL: begin
                result_o = info_i.in_range ? lft[LOG_W] : '0;
                if (!info_i.is_zero)
                    carry_o = info_i.in_range ? data_i[up_idx]
                            : (info_i.exact_w ? data_i[0] : 1'b0);
            end
            SK_LSR: begin
                result_o = info_i.in_range ? rgt[LOG_W] : '0;
                if (!info_i.is_zero)
                    carry_o = info_i.in_range ? data_i[dn_idx]
                            : (info_i.exact_w ? sign : 1'b0);
            end
            SK_ASR: begin
                result_o = info_i.in_range ? rgt[LOG_W] : {DATA_W{sign}};
                if (!info_i.is_zero)
                    carry_o = info_i.in_range ? data_i[dn_idx] : sign;
            end
            SK_ROR: begin
                result_o = rot[LOG_W];
                if (!info_i.is_zero)
                    carry_o = rot[LOG_W][DATA_W-1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bsh_probe.sv
module bsh_probe #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int LOG_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  idx_i,
    output logic              bit_o
);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(DATA_W);
    localparam logic [LOG_W-1:0] TOP   = LOG_W'(DATA_W - 1);

    logic [DATA_W-1:0] raised;
    logic [LOG_W-1:0]  up;

    // lift the chosen bit to the top, then bring it alone down to bit 0
    assign up     = TOP - idx_i[LOG_W-1:0];
    assign raised = data_i << up;
    assign bit_o  = (idx_i < W_AMT) ? |(raised >> (DATA_W - 1)) : 1'b0;
endmodule

// File: rtl/bsh_top.sv
module bsh_top
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [1:0]        kind_i,
    input  logic [AMT_W-1:0]  probe_idx_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              probe_o
);
    localparam int LOG_W = $clog2(DATA_W);

    amt_info_t        info;
    logic [LOG_W-1:0] low;
    shift_kind_e      kind;

    assign kind = shift_kind_e'(kind_i);

    bsh_amt_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
        .amt_i  (amt_i),
        .info_o (info),
        .low_o  (low)
    );

    bsh_core #(.DATA_W(DATA_W)) u_core (
        .data_i   (data_i),
        .kind_i   (kind),
        .info_i   (info),
        .low_i    (low),
        .result_o (result_o),
        .carry_o  (carry_o)
    );

    bsh_probe #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_probe (
        .data_i (data_i),
        .idx_i  (probe_idx_i),
        .bit_o  (probe_o)
    );
endmodule

// File: rtl/bsh_chk.sv
module bsh_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input logic [DATA_W-1:0] data_i,
    input logic [AMT_W-1:0]  amt_i,
    input logic [1:0]        kind_i,
    input logic [AMT_W-1:0]  probe_idx_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o,
    input logic              probe_o
);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(DATA_W);

    always_comb begin
        if (!$isunknown({data_i, amt_i, kind_i, probe_idx_i, result_o, carry_o, probe_o})) begin
            // R2
            zero_amt_chk: assert (amt_i != '0 || (result_o == data_i && !carry_o))
                else $error("zero amount altered word or carry");
            // R9
            ror_weight_chk: assert (kind_i != 2'd3 || $countones(result_o) == $countones(data_i))
                else $error("rotate changed the number of set bits");
            // R4
            lsl_wide_chk: assert (!(kind_i == 2'd0 && amt_i >= W_AMT) || result_o == '0)
                else $error("wide left shift not zero");
            // R6
            lsr_wide_chk: assert (!(kind_i == 2'd2 && amt_i >= W_AMT) || result_o == '0)
                else $error("wide right shift not zero");
            // R8
            asr_sign_chk: assert (kind_i != 2'd1 || result_o[DATA_W-1] == data_i[DATA_W-1])
                else $error("arithmetic shift lost the sign");
            // R10
            probe_range_chk: assert (probe_idx_i < W_AMT || !probe_o)
                else $error("probe past the top bit not zero");
        end
    end
endmodule

bind bsh_top bsh_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .data_i      (data_i),
    .amt_i       (amt_i),
    .kind_i      (kind_i),
    .probe_idx_i (probe_idx_i),
    .result_o    (result_o),
    .carry_o     (carry_o),
    .probe_o     (probe_o)
);

// File: tb/tb_bsh_top.sv
module tb_bsh_top;
    localparam int DATA_W = 32;
    localparam int AMT_W  = 8;

    typedef struct {
        logic [31:0] exp_res;
        logic        exp_c;
        logic        exp_p;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] data_i = '0;
    logic [AMT_W-1:0]  amt_i = '0;
    logic [1:0]        kind_i = '0;
    logic [AMT_W-1:0]  probe_idx_i = '0;
    logic [DATA_W-1:0] result_o;
    logic              carry_o;
    logic              probe_o;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    bsh_top #(.DATA_W(DATA_W), .AMT_W(AMT_W)) dut (
        .data_i(data_i), .amt_i(amt_i), .kind_i(kind_i), .probe_idx_i(probe_idx_i),
        .result_o(result_o), .carry_o(carry_o), .probe_o(probe_o)
    );

    // bit-by-bit model written from the requirements
    function automatic void model(input logic [31:0] d, input int s, input int k,
                                  output logic [31:0] r, output logic c);
        for (int i = 0; i < 32; i++) begin
            int src;
            case (k)
                0: begin src = i - s; r[i] = (src >= 0) ? d[src] : 1'b0; end
                1: begin src = i + s; r[i] = (src < 32) ? d[src] : d[31]; end
                2: begin src = i + s; r[i] = (src < 32) ? d[src] : 1'b0; end
                default: r[i] = d[(i + s) % 32];
            endcase
        end
        if (s == 0) c = 1'b0;
        else case (k)
            0: c = (s <= 32) ? d[32 - s] : 1'b0;
            1: c = (s <= 32) ? d[s - 1] : d[31];
            2: c = (s <= 32) ? d[s - 1] : 1'b0;
            default: c = r[31];
        endcase
    endfunction

    task automatic drive(input logic [31:0] d, input int s, input int k, input int idx,
                         input string tag, input bit use_lit, input logic [31:0] lit);
        item_t it;
        logic [31:0] r;
        logic c;
        @(posedge clk);
        data_i = d; amt_i = AMT_W'(s); kind_i = 2'(k); probe_idx_i = AMT_W'(idx);
        model(d, s, k, r, c);
        it.exp_res = use_lit ? lit : r;
        it.exp_c   = c;
        it.exp_p   = (idx < 32) ? d[idx] : 1'b0;
        it.tag     = tag;
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (result_o !== it.exp_res) begin
                bad++;
                $display("FAIL %s result act=%h exp=%h", it.tag, result_o, it.exp_res);
            end
            total++;
            if (carry_o !== it.exp_c) begin
                bad++;
                $display("FAIL %s carry act=%b exp=%b", it.tag, carry_o, it.exp_c);
            end
            total++;
            if (probe_o !== it.exp_p) begin
                bad++;
                $display("FAIL %s probe act=%b exp=%b", it.tag, probe_o, it.exp_p);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs, R2
        drive(32'h0, 0, 0, 0, "R2 reset", 1'b1, 32'h0);
        // R2 zero amount in every mode
        for (int k = 0; k < 4; k++) drive(32'hA5C3_0F81, 0, k, 7, "R2", 1'b1, 32'hA5C3_0F81);
        // R1 code mapping with one word, amount 4
        drive(32'h8000_00F0, 4, 0, 4, "R1 R3", 1'b1, 32'h0000_0F00);
        drive(32'h8000_00F0, 4, 1, 31, "R1 R7", 1'b1, 32'hF800_000F);
        drive(32'h8000_00F0, 4, 2, 5, "R1 R5", 1'b1, 32'h0800_000F);
        drive(32'h8000_00F0, 4, 3, 0, "R1 R9", 1'b1, 32'h0800_000F);
        // R3 / R4
        drive(32'hF000_0001, 31, 0, 0, "R3", 1'b1, 32'h8000_0000);
        drive(32'hF000_0001, 32, 0, 31, "R4", 1'b1, 32'h0);
        drive(32'hF000_0001, 100, 0, 1, "R4", 1'b1, 32'h0);
        drive(32'hFFFF_FFFF, 255, 0, 32, "R4", 1'b1, 32'h0);
        // R5 / R6
        drive(32'hFFFF_FFFE, 1, 2, 0, "R5", 1'b1, 32'h7FFF_FFFF);
        drive(32'h8000_0000, 32, 2, 31, "R6", 1'b1, 32'h0);
        drive(32'h8000_0000, 33, 2, 40, "R6", 1'b1, 32'h0);
        // R7 / R8
        drive(32'hFF00_0100, 8, 1, 8, "R7", 1'b1, 32'hFFFF_0001);
        drive(32'hFFFF_FFF1, 2, 1, 3, "R7", 1'b1, 32'hFFFF_FFFC);
        drive(32'h8000_1234, 32, 1, 2, "R8", 1'b1, 32'hFFFF_FFFF);
        drive(32'h7FFF_FFFF, 200, 1, 30, "R8", 1'b1, 32'h0);
        // R9
        drive(32'h0E00_0010, 12, 3, 4, "R9", 1'b1, 32'h0100_E000);
        drive(32'h00FF_FF00, 12, 3, 8, "R9", 1'b1, 32'hF000_0FFF);
        drive(32'hF000_0001, 32, 3, 0, "R9", 1'b1, 32'hF000_0001);
        drive(32'hF000_0001, 64, 3, 28, "R9", 1'b1, 32'hF000_0001);
        // R10 probe boundaries
        drive(32'h8000_0001, 0, 0, 31, "R10", 1'b0, 32'h0);
        drive(32'hFFFF_FFFF, 0, 0, 32, "R10", 1'b0, 32'h0);
        drive(32'hFFFF_FFFF, 0, 0, 255, "R10", 1'b0, 32'h0);
        // random vectors, tagged by operation
        for (int n = 0; n < 400; n++) begin
            logic [31:0] d;
            int s, k, idx;
            string t;
            d   = $urandom;
            k   = $urandom_range(0, 3);
            s   = (n % 4 == 0) ? $urandom_range(0, 255) : $urandom_range(0, 40);
            idx = $urandom_range(0, 63);
            case (k)
                0: t = (s >= 32) ? "R4 rnd" : "R3 rnd";
                1: t = (s >= 32) ? "R8 rnd" : "R7 rnd";
                2: t = (s >= 32) ? "R6 rnd" : "R5 rnd";
                default: t = "R9 R10 rnd";
            endcase
            drive(d, s, k, idx, t, 1'b0, 32'h0);
        end
        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule